// File: doc/BRIEF.md
# Three-Stage Escalating Watchdog Timer

This block is a single watchdog timer with a 64-bit register interface. Software writes a control word that holds a run mode, a 16-bit reload length and a 24-bit live count. It then keeps the timer alive by writing a keep-alive word at regular intervals. The count drops by one on each prescaled tick, which is one tick per 2^PRE_LOG2 input clocks.

When a tick finds the count at zero, the timer has expired. It then reloads the count from the length and moves to its next escalation stage. The first expiry latches an interrupt-pending flag. The interrupt output is that flag gated by an enable bit. The second expiry is a grace stage and has no visible effect. The third expiry raises a reset request, which holds until the block itself is reset.

The register bus is synchronous. A write takes effect at the clock edge where `wr_en` is high. A read returns its word on `rdata` one cycle after `rd_en`.

Top module: `wdt_escalate`

## Requirements
- R1: After reset, `irq` and `rst_req` are low, and reads of the control word, the pending word (0x200) and the enable words (0x210, 0x218) return zero.
- R2: The control word is at byte offset 0x1F8, and its fields are as follows. Bits [1:0] hold the mode. Bits [19:4] hold the length. Bits [43:20] hold the count. All other bits read zero. One write loads all three fields, and a read returns them on `rdata` in the cycle after `rd_en`.
- R3: With mode 3, the count falls by one every 2^PRE_LOG2 clocks, and an expiry happens on the tick that finds it at zero. A control write restarts the prescaler. After a control write of count C, the first expiry therefore takes effect at the clock edge 2^PRE_LOG2·(C+1) cycles after the write edge.
- R4: The first expiry sets the pending flag, which reads back in bit 63 of offset 0x200. At that expiry the count reloads with the length in bits [23:8] and zeros in bits [7:0].
- R5: The second expiry leaves the pending flag, `irq` and `rst_req` unchanged, and reloads the count the same way.
- R6: The third expiry raises `rst_req`. After that, counting stops. `rst_req` stays high through keep-alive and mode writes until `rst` is applied.
- R7: Writing a word with bit 63 set to offset 0x101F8 reloads the count from the length, returns the stage to the first expiry and restarts the prescaler. Such a write with bit 63 clear has no effect.
- R8: While the mode is not 3, the count holds its value and the stage goes back to the first expiry. Re-entering mode 3 therefore starts the sequence again from the interrupt stage.
- R9: Writing 1 to bit 63 of offset 0x200 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R10: Writing 1 to bit 63 of 0x218 sets the interrupt enable, and writing 1 to bit 63 of 0x210 clears it. Reads of either offset return the enable in bit 63. `irq` is high exactly when both the pending flag and the enable are set.
- R11: Reads of any offset that is not mapped return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 17 | Byte offset of the register access |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Pending flag gated by the enable |
| rst_req | output | 1 | Sticky reset request raised by the third expiry |

## Verification
The hardest state to reach is the reset request. It needs three expiries in a row without a keep-alive in between. Two of those expiries reload from the length, which gives at least 256 ticks each. The bench instantiates the block with a 4-clock tick, so a length of 1 spaces the expiries 1028 cycles apart. It also clears the pending flag between stages, so it can show that the second expiry stays silent. The earlier expiries are timed by writing small counts directly. Random counts and lengths are used to check the exact expiry edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W  = 17;
    localparam int DATA_W  = 64;
    localparam int CNT_W   = 24;
    localparam int LEN_W   = 16;
    localparam int LOW_W   = CNT_W - LEN_W;
    localparam int MODE_W  = 2;
    localparam int LEN_LSB = 4;
    localparam int CNT_LSB = 20;
    localparam int KEY_BIT = 63;

    localparam logic [ADDR_W-1:0] A_CTRL  = 17'h001F8;
    localparam logic [ADDR_W-1:0] A_PEND  = 17'h00200;
    localparam logic [ADDR_W-1:0] A_ENCLR = 17'h00210;
    localparam logic [ADDR_W-1:0] A_ENSET = 17'h00218;
    localparam logic [ADDR_W-1:0] A_KICK  = 17'h101F8;

    localparam logic [MODE_W-1:0] MODE_ARMED = 2'd3;

    typedef enum logic [1:0] {
        STG_WARN  = 2'd0,
        STG_GRACE = 2'd1,
        STG_FINAL = 2'd2,
        STG_DONE  = 2'd3
    } stage_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic [CNT_W-1:0] reload_of(input logic [LEN_W-1:0] len);
        return {len, {LOW_W{1'b0}}};
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_image(input logic [MODE_W-1:0] mode,
                                                     input logic [LEN_W-1:0]  len,
                                                     input logic [CNT_W-1:0]  cnt);
        logic [DATA_W-1:0] v;
        v = '0;
        v[MODE_W-1:0]          = mode;
        v[LEN_LSB +: LEN_W]    = len;
        v[CNT_LSB +: CNT_W]    = cnt;
        return v;
    endfunction
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int PRE_LOG2 = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic tick
);
    logic [PRE_LOG2-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    assign tick = run && (&div_q);
endmodule

// File: rtl/wdt_core.sv
module wdt_core import wdt_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             kick,
    input  logic             ld_cnt,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] cnt_q,
    output stage_t           stage_q,
    output logic             warn_evt,
    output logic             rreq_q
);
    logic live;
    logic expire;

    assign live     = (stage_q != STG_DONE);
    assign expire   = tick && live && (cnt_q == '0) && !kick && !ld_cnt;
    assign warn_evt = expire && (stage_q == STG_WARN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            stage_q <= STG_WARN;
            rreq_q  <= 1'b0;
        end else begin
            if (kick && live) begin
                cnt_q   <= reload_of(len);
                stage_q <= STG_WARN;
            end else if (ld_cnt) begin
                cnt_q <= ld_val;
            end else if (tick && live) begin
                if (cnt_q == '0) begin
                    cnt_q   <= reload_of(len);
                    stage_q <= stage_t'(stage_q + 2'd1);
                    if (stage_q == STG_FINAL) rreq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (!run && live) stage_q <= STG_WARN;
        end
    end
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [CNT_W-1:0]  cnt_now,
    input  logic              warn_evt,
    output logic [MODE_W-1:0] mode_q,
    output logic [LEN_W-1:0]  len_q,
    output logic              ld_cnt,
    output logic [CNT_W-1:0]  ld_val,
    output logic              kick,
    output logic              pend_q,
    output logic              ena_q,
    output logic [DATA_W-1:0] rdata_q
);
    logic              key;
    logic [DATA_W-1:0] rd_word;

    assign key    = req.data[KEY_BIT];
    assign ld_cnt = req.wr && (req.addr == A_CTRL);
    assign ld_val = req.data[CNT_LSB +: CNT_W];
    assign kick   = req.wr && (req.addr == A_KICK) && key;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            len_q  <= '0;
        end else if (ld_cnt) begin
            mode_q <= req.data[MODE_W-1:0];
            len_q  <= req.data[LEN_LSB +: LEN_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                         pend_q <= 1'b0;
        else if (warn_evt)                               pend_q <= 1'b1;
        else if (req.wr && (req.addr == A_PEND) && key)  pend_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                                          ena_q <= 1'b0;
        else if (req.wr && (req.addr == A_ENSET) && key)  ena_q <= 1'b1;
        else if (req.wr && (req.addr == A_ENCLR) && key)  ena_q <= 1'b0;
    end

    always_comb begin
        rd_word = '0;
        case (req.addr)
            A_CTRL:          rd_word = ctrl_image(mode_q, len_q, cnt_now);
            A_PEND:          rd_word[KEY_BIT] = pend_q;
            A_ENCLR, A_ENSET: rd_word[KEY_BIT] = ena_q;
            default:         rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (req.rd) rdata_q <= rd_word;
    end
endmodule

// File: rtl/wdt_escalate.sv
module wdt_escalate import wdt_pkg::*; #(
    parameter int PRE_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    bus_req_t          req;
    logic [MODE_W-1:0] mode_q;
    logic [LEN_W-1:0]  len_q;
    logic              ld_cnt;
    logic [CNT_W-1:0]  ld_val;
    logic              kick;
    logic              pend_q;
    logic              ena_q;
    logic              run;
    logic              tick;
    logic [CNT_W-1:0]  cnt_q;
    stage_t            stage_q;
    logic              warn_evt;

    assign req = '{wr: wr_en, rd: rd_en, addr: addr, data: wdata};
    assign run = (mode_q == MODE_ARMED);

    wdt_regs u_regs (
        .clk(clk), .rst(rst), .req(req), .cnt_now(cnt_q), .warn_evt(warn_evt),
        .mode_q(mode_q), .len_q(len_q), .ld_cnt(ld_cnt), .ld_val(ld_val),
        .kick(kick), .pend_q(pend_q), .ena_q(ena_q), .rdata_q(rdata)
    );

    wdt_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
        .clk(clk), .rst(rst), .restart(ld_cnt | kick), .run(run), .tick(tick)
    );

    wdt_core u_core (
        .clk(clk), .rst(rst), .run(run), .tick(tick), .kick(kick),
        .ld_cnt(ld_cnt), .ld_val(ld_val), .len(len_q), .cnt_q(cnt_q),
        .stage_q(stage_q), .warn_evt(warn_evt), .rreq_q(rst_req)
    );

    assign irq = pend_q & ena_q;
endmodule

// File: rtl/wdt_escalate_chk.sv
module wdt_escalate_chk import wdt_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              rst_req,
    input logic              run,
    input logic [CNT_W-1:0]  cnt,
    input stage_t            stage,
    input logic [LEN_W-1:0]  len
);
    AST_RST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> rst_req); // R6

    AST_RST_REQ_FROM_FINAL: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> ($past(stage) == STG_FINAL)); // R6

    AST_KICK_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_KICK && wdata[KEY_BIT] && stage != STG_DONE)
        |=> (cnt == {$past(len), {LOW_W{1'b0}}} && stage == STG_WARN)); // R7

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(cnt)); // R8

    AST_ENA_CLEAR_QUIETS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_ENCLR && wdata[KEY_BIT]) |=> !irq); // R10

    AST_STAGE_STEPS: assert property (@(posedge clk) disable iff (rst)
        (stage != $past(stage)) |->
        (stage == STG_WARN || stage == stage_t'($past(stage) + 2'd1))); // R5
endmodule

bind wdt_escalate wdt_escalate_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq(irq), .rst_req(rst_req), .run(run), .cnt(cnt_q),
    .stage(stage_q), .len(len_q)
);

// File: tb/wdt_escalate_tb_top.sv
`timescale 1ns/1ps
module wdt_escalate_tb_top;
    localparam int P    = 2;
    localparam int STEP = 1 << P;
    localparam logic [16:0] O_CTRL = 17'h001F8, O_PEND = 17'h00200,
                            O_ENCLR = 17'h00210, O_ENSET = 17'h00218,
                            O_KICK = 17'h101F8;
    localparam logic [63:0] KEY = 64'h1 << 63;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [16:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        irq, rst_req;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_escalate #(.PRE_LOG2(P)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    function automatic logic [63:0] exp_ctrl(input logic [1:0] m, input logic [15:0] l,
                                             input logic [23:0] c);
        return {20'h0, c, l, 2'b00, m};
    endfunction

    function automatic int fire_delay(input int c);
        return STEP * (c + 1);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [16:0] a, input logic [63:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [16:0] a, output logic [63:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        logic [63:0] d, r;
        void'($urandom(32'd4242));
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);

        // R1 reset state
        chk("R1 irq", {63'h0, irq}, 64'h0);
        chk("R1 rst_req", {63'h0, rst_req}, 64'h0);
        bus_rd(O_CTRL, r);  chk("R1 ctrl", r, 64'h0);
        bus_rd(O_PEND, r);  chk("R1 pend", r, 64'h0);
        bus_rd(O_ENSET, r); chk("R1 ena", r, 64'h0);

        // R2 field layout with mode 0 (no counting)
        for (int i = 0; i < 4; i++) begin
            d = {$urandom(), $urandom()};
            d[1:0] = 2'b00;
            bus_wr(O_CTRL, d);
            bus_rd(O_CTRL, r);
            chk("R2 ctrl readback", r, exp_ctrl(2'b00, d[19:4], d[43:20]));
        end

        // R8 non-run mode holds the count
        bus_wr(O_CTRL, exp_ctrl(2'd2, 16'h0005, 24'd7));
        wait_cyc(20);
        bus_rd(O_CTRL, r);
        chk("R8 count held in mode 2", r, exp_ctrl(2'd2, 16'h0005, 24'd7));

        // R11 unmapped reads
        bus_rd(17'h00208, r); chk("R11 unmapped 0x208", r, 64'h0);
        bus_rd(17'h001F0, r); chk("R11 unmapped 0x1F0", r, 64'h0);

        // R10 enable set, readable at both offsets
        bus_wr(O_ENSET, KEY);
        bus_rd(O_ENCLR, r); chk("R10 ena via clr offset", r, KEY);
        bus_rd(O_ENSET, r); chk("R10 ena via set offset", r, KEY);

        // R3/R4 random expiry timing
        for (int i = 0; i < 6; i++) begin
            int c;
            logic [15:0] l;
            c = $urandom_range(0, 12);
            l = 16'($urandom());
            if (l == 0) l = 16'h1;
            bus_wr(O_CTRL, 64'h0);
            bus_wr(O_PEND, KEY);
            bus_wr(O_CTRL, exp_ctrl(2'd3, l, 24'(c)));
            wait_cyc(fire_delay(c) - 1);
            chk("R3 no expiry one cycle early", {63'h0, irq}, 64'h0);
            wait_cyc(1);
            chk("R4 first expiry sets irq", {63'h0, irq}, 64'h1);
            bus_rd(O_CTRL, r);
            chk("R4 reload after first expiry", r, exp_ctrl(2'd3, l, {l, 8'h00}));
        end

        // R5/R6 full escalation with length 1
        bus_wr(O_CTRL, 64'h0);
        bus_wr(O_PEND, KEY);
        bus_wr(O_CTRL, exp_ctrl(2'd3, 16'h0001, 24'd0));
        wait_cyc(fire_delay(0));
        chk("R4 first expiry", {63'h0, irq}, 64'h1);
        bus_wr(O_PEND, KEY);
        wait_cyc(1027);
        chk("R5 second expiry silent irq", {63'h0, irq}, 64'h0);
        chk("R5 second expiry no rst_req", {63'h0, rst_req}, 64'h0);
        bus_rd(O_CTRL, r);
        chk("R5 reload after second expiry", r, exp_ctrl(2'd3, 16'h0001, 24'd256));
        wait_cyc(1026);
        chk("R6 rst_req low before third", {63'h0, rst_req}, 64'h0);
        wait_cyc(1);
        chk("R6 rst_req on third expiry", {63'h0, rst_req}, 64'h1);
        bus_wr(O_KICK, KEY);
        bus_wr(O_CTRL, 64'h0);
        wait_cyc(10);
        chk("R6 rst_req sticky", {63'h0, rst_req}, 64'h1);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
        chk("R6 rst_req cleared by reset", {63'h0, rst_req}, 64'h0);
        bus_wr(O_ENSET, KEY);

        // R7 keep-alive
        bus_wr(O_CTRL, exp_ctrl(2'd3, 16'h0002, 24'd5));
        bus_wr(O_KICK, 64'h0);
        bus_rd(O_CTRL, r);
        chk("R7 keep-alive without key ignored", r, exp_ctrl(2'd3, 16'h0002, 24'd5));
        bus_wr(O_KICK, KEY);
        bus_rd(O_CTRL, r);
        chk("R7 keep-alive reloads", r, exp_ctrl(2'd3, 16'h0002, 24'd512));
        bus_wr(O_CTRL, exp_ctrl(2'd3, 16'h0002, 24'd0));
        wait_cyc(fire_delay(0));
        chk("R4 expiry after keep-alive", {63'h0, irq}, 64'h1);
        bus_wr(O_PEND, KEY);
        bus_wr(O_KICK, KEY);
        bus_wr(O_CTRL, exp_ctrl(2'd3, 16'h0002, 24'd0));
        wait_cyc(fire_delay(0));
        chk("R7 keep-alive restarts stage", {63'h0, irq}, 64'h1);

        // R8 mode 0 restarts the sequence
        bus_wr(O_CTRL, 64'h0);
        bus_wr(O_PEND, KEY);
        bus_wr(O_CTRL, exp_ctrl(2'd3, 16'h0002, 24'd1));
        wait_cyc(fire_delay(1) - 1);
        chk("R8 not yet expired", {63'h0, irq}, 64'h0);
        wait_cyc(1);
        chk("R8 restart gives interrupt stage", {63'h0, irq}, 64'h1);

        // R9 pending clear
        bus_wr(O_CTRL, 64'h0);
        bus_wr(O_PEND, 64'h0);
        bus_rd(O_PEND, r); chk("R9 write 0 keeps pending", r, KEY);
        // R10 gating by enable
        bus_wr(O_ENCLR, KEY);
        chk("R10 irq off when disabled", {63'h0, irq}, 64'h0);
        bus_rd(O_PEND, r); chk("R10 pending kept while disabled", r, KEY);
        bus_wr(O_ENSET, KEY);
        chk("R10 irq back on", {63'h0, irq}, 64'h1);
        bus_wr(O_PEND, KEY);
        bus_rd(O_PEND, r); chk("R9 write 1 clears pending", r, 64'h0);
        chk("R9 irq low after clear", {63'h0, irq}, 64'h0);

        done = 1'b1;
        finish_run();
    end
endmodule